// File: doc/BRIEF.md
# Set/Clear GPIO Port

This block is a 32-pin general-purpose I/O port that sits on a simple register bus. Software never has to read a register, change it and write it back. Instead it raises output bits through one address and lowers them through another. A second pair of addresses turns individual pad drivers on or off in the same way. Each pad is modelled as three vectors: an output level, an output enable, and a sampled input level.

Pad levels enter through a two-flop synchronizer, and a read-only location returns the synchronized value. Every bus request is acknowledged on the following clock edge. Read data is valid only while the acknowledge is high and is zero at all other times. The block is meant for slow control lines, such as a bit-banged management clock and data pair. On such lines firmware toggles single pins many times, and set/clear addressing keeps each toggle to one bus write.

Top module: `gpio_setclr_port`

## Requirements
- R1: While reset is asserted and after it is released, pad_out and pad_oe are all zero, and bus_ack and bus_rdata are zero.
- R2: A write to offset 0x00 sets every pad_out bit whose bit in bus_wdata is 1. All other pad_out bits keep their value.
- R3: A write to offset 0x10 clears every pad_out bit whose bit in bus_wdata is 1. All other pad_out bits keep their value.
- R4: A write to offset 0x20 sets every pad_oe bit whose bit in bus_wdata is 1, turning that pad driver on. All other bits keep their value.
- R5: A write to offset 0x30 clears every pad_oe bit whose bit in bus_wdata is 1, tri-stating that pad. All other bits keep their value.
- R6: A read of offset 0x40 returns pad_in passed through two flops. The data acknowledged after clock edge e equals pad_in as sampled at edge e-2, with bit n belonging to pin n.
- R7: A read of offset 0x00 or 0x10 returns the current pad_out. A read of offset 0x20 or 0x30 returns the current pad_oe.
- R8: A read of any offset other than 0x00, 0x10, 0x20, 0x30 or 0x40 returns zero. A write to such an offset, or to 0x40, changes neither pad_out nor pad_oe.
- R9: A request sampled with bus_req high at one edge is answered by bus_ack high for the cycle after that edge. bus_ack is low after an edge where bus_req was low. bus_rdata is zero whenever bus_ack is low.
- R10: A write of an all-zero data word to any of the four set/clear offsets leaves pad_out and pad_oe unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Bus request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data, used as a bit mask |
| bus_ack | output | 1 | Acknowledge, one cycle after each request |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Output latch levels |
| pad_oe | output | 32 | Output driver enables |

## Verification
Two of the block's functions can fall in the same cycle: a read of the pin-level location, and a change of pad_in on its way through the synchronizer. The bench provokes this by changing pad_in on the same cycle a burst of back-to-back reads of offset 0x40 begins. It expects the old level for the first two answers and the new level from the third answer on. A behavioural model keeps a short history of sampled pad_in values and judges every cycle against it, including random traffic that mixes set/clear writes with pin reads while pad_in changes.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

  // Register selection decoded from the bus offset
  typedef enum logic [2:0] {
    GSP_NONE,
    GSP_OUT_SET,
    GSP_OUT_CLR,
    GSP_OE_SET,
    GSP_OE_CLR,
    GSP_PIN_LVL
  } gsp_sel_e;

  // Byte offsets; software depends on these values
  localparam int unsigned GSP_OFF_OUT_SET = 32'h00;
  localparam int unsigned GSP_OFF_OUT_CLR = 32'h10;
  localparam int unsigned GSP_OFF_OE_SET  = 32'h20;
  localparam int unsigned GSP_OFF_OE_CLR  = 32'h30;
  localparam int unsigned GSP_OFF_PIN_LVL = 32'h40;

endpackage

// File: rtl/gsp_decode.sv
module gsp_decode
  import gsp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  output gsp_sel_e      sel
);

  always_comb begin
    if (addr == AW'(GSP_OFF_OUT_SET))      sel = GSP_OUT_SET;
    else if (addr == AW'(GSP_OFF_OUT_CLR)) sel = GSP_OUT_CLR;
    else if (addr == AW'(GSP_OFF_OE_SET))  sel = GSP_OE_SET;
    else if (addr == AW'(GSP_OFF_OE_CLR))  sel = GSP_OE_CLR;
    else if (addr == AW'(GSP_OFF_PIN_LVL)) sel = GSP_PIN_LVL;
    else                                   sel = GSP_NONE;
  end

endmodule

// File: rtl/gsp_setclr_reg.sv
module gsp_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);

  // Next value of the latch for one set or clear event
  function automatic logic [W-1:0] next_bits(input logic [W-1:0] cur,
                                             input logic set_i,
                                             input logic clr_i,
                                             input logic [W-1:0] m);
    logic [W-1:0] r;
    r = cur;
    if (set_i) r = r | m;
    if (clr_i) r = r & ~m;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_bits(q, set_en, clr_en, mask);
  end

  AST_SET_REACHES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(mask)) == $past(mask)));  // R2
  AST_CLR_REACHES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(mask)) == '0));  // R3
  AST_OTHER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en || clr_en) |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));  // R5
  AST_ZERO_MASK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> $stable(q));  // R10
  AST_IDLE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(q));  // R8

endmodule

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];

  // Cycles since reset, saturating at STAGES, so the delay check
  // never reaches back into reset
  logic [7:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    warm_q <= '0;
    else if (warm_q != 8'(STAGES)) warm_q <= warm_q + 8'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 8'(STAGES)) |-> (dout == $past(din, STAGES)));  // R6

endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gsp_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic          bus_ack,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe
);

  gsp_sel_e     sel;
  logic [W-1:0] pin_lvl;

  // Named access events
  logic wr_hit, rd_hit;
  logic ev_out_set, ev_out_clr, ev_oe_set, ev_oe_clr;

  assign wr_hit     = bus_req &&  bus_we;
  assign rd_hit     = bus_req && !bus_we;
  assign ev_out_set = wr_hit && (sel == GSP_OUT_SET);
  assign ev_out_clr = wr_hit && (sel == GSP_OUT_CLR);
  assign ev_oe_set  = wr_hit && (sel == GSP_OE_SET);
  assign ev_oe_clr  = wr_hit && (sel == GSP_OE_CLR);

  gsp_decode #(.AW(AW)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  gsp_setclr_reg #(.W(W)) u_out_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (ev_out_set),
    .clr_en (ev_out_clr),
    .mask   (bus_wdata),
    .q      (pad_out)
  );

  gsp_setclr_reg #(.W(W)) u_oe_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (ev_oe_set),
    .clr_en (ev_oe_clr),
    .mask   (bus_wdata),
    .q      (pad_oe)
  );

  gsp_sync #(.W(W), .STAGES(2)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pad_in),
    .dout  (pin_lvl)
  );

  // Read-back word for a decoded selection
  function automatic logic [W-1:0] read_word(input gsp_sel_e s,
                                             input logic [W-1:0] o,
                                             input logic [W-1:0] e,
                                             input logic [W-1:0] l);
    case (s)
      GSP_OUT_SET, GSP_OUT_CLR: return o;
      GSP_OE_SET,  GSP_OE_CLR:  return e;
      GSP_PIN_LVL:              return l;
      default:                  return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_rdata <= rd_hit ? read_word(sel, pad_out, pad_oe, pin_lvl) : '0;
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_out_set, ev_out_clr, ev_oe_set, ev_oe_clr}));  // R8
  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack);  // R9
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ack);  // R9
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (bus_rdata == '0));  // R9
  AST_READ_OUT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && (sel == GSP_OUT_SET || sel == GSP_OUT_CLR)) |=>
      (bus_rdata == $past(pad_out)));  // R7
  AST_READ_OE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && (sel == GSP_OE_SET || sel == GSP_OE_CLR)) |=>
      (bus_rdata == $past(pad_oe)));  // R7
  AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (sel == GSP_NONE || sel == GSP_PIN_LVL)) |=>
      ($stable(pad_out) && $stable(pad_oe)));  // R8
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sel == GSP_NONE) |=> (bus_rdata == '0));  // R8
  AST_OE_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_oe_set |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));  // R4

endmodule

// File: tb/gpio_setclr_port_tb.sv
module gpio_setclr_port_tb_top;

  localparam logic [7:0] A_OSET = 8'h00;
  localparam logic [7:0] A_OCLR = 8'h10;
  localparam logic [7:0] A_ESET = 8'h20;
  localparam logic [7:0] A_ECLR = 8'h30;
  localparam logic [7:0] A_PIN  = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in, pad_out, pad_oe;

  int tests = 0;
  int fails = 0;
  bit run_cmp = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_setclr_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_out, m_oe, m_rdata;
  logic        m_ack;
  logic [31:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_oe = '0; m_ack = 1'b0; m_rdata = '0;
      hist.delete();
    end else begin
      logic [31:0] lvl;
      lvl = (hist.size() >= 2) ? hist[hist.size()-2] : 32'h0;
      m_ack = bus_req;
      m_rdata = '0;
      if (bus_req && !bus_we) begin
        case (bus_addr)
          A_OSET, A_OCLR: m_rdata = m_out;
          A_ESET, A_ECLR: m_rdata = m_oe;
          A_PIN:          m_rdata = lvl;
          default:        m_rdata = '0;
        endcase
      end
      if (bus_req && bus_we) begin
        case (bus_addr)
          A_OSET: m_out = m_out | bus_wdata;
          A_OCLR: m_out = m_out & ~bus_wdata;
          A_ESET: m_oe  = m_oe | bus_wdata;
          A_ECLR: m_oe  = m_oe & ~bus_wdata;
          default: ;
        endcase
      end
      hist.push_back(pad_in);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk("R9 model ack", {31'd0, bus_ack}, {31'd0, m_ack});
      chk("R6 R7 R8 model rdata", bus_rdata, m_rdata);
      chk("R2 R3 R10 model pad_out", pad_out, m_out);
      chk("R4 R5 R10 model pad_oe", pad_oe, m_oe);
    end
  end

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 pad_out in reset", pad_out, 32'h0);
    chk("R1 pad_oe in reset", pad_oe, 32'h0);
    chk("R1 ack in reset", {31'd0, bus_ack}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pad_out after reset", pad_out, 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    run_cmp = 1'b1;

    do_write(A_OSET, 32'hA5A5_00F0);
    chk("R2 set", pad_out, 32'hA5A5_00F0);
    do_write(A_OCLR, 32'h0000_00A0);
    chk("R3 clear", pad_out, 32'hA5A5_0050);
    do_write(A_ESET, 32'hFFFF_0000);
    chk("R4 enable", pad_oe, 32'hFFFF_0000);
    do_write(A_ECLR, 32'h0F0F_0000);
    chk("R5 tristate", pad_oe, 32'hF0F0_0000);
    chk("R5 outputs untouched", pad_out, 32'hA5A5_0050);

    do_read(A_OSET, rd); chk("R7 read 0x00", rd, 32'hA5A5_0050);
    do_read(A_OCLR, rd); chk("R7 read 0x10", rd, 32'hA5A5_0050);
    do_read(A_ESET, rd); chk("R7 read 0x20", rd, 32'hF0F0_0000);
    do_read(A_ECLR, rd); chk("R7 read 0x30", rd, 32'hF0F0_0000);

    do_write(A_OSET, 32'h0); do_write(A_OCLR, 32'h0);
    do_write(A_ESET, 32'h0); do_write(A_ECLR, 32'h0);
    chk("R10 zero write pad_out", pad_out, 32'hA5A5_0050);
    chk("R10 zero write pad_oe", pad_oe, 32'hF0F0_0000);

    do_write(A_PIN, 32'hFFFF_FFFF);
    do_write(8'h44, 32'hFFFF_FFFF);
    do_write(8'h08, 32'hFFFF_FFFF);
    chk("R8 ignored write pad_out", pad_out, 32'hA5A5_0050);
    chk("R8 ignored write pad_oe", pad_oe, 32'hF0F0_0000);
    do_read(8'h44, rd); chk("R8 unmapped read 0x44", rd, 32'h0);
    do_read(8'hFF, rd); chk("R8 unmapped read 0xFF", rd, 32'h0);

    do_write(A_OSET, 32'h8000_0001);
    chk("R2 edge bits", pad_out & 32'h8000_0001, 32'h8000_0001);
    do_write(A_OCLR, 32'hFFFF_FFFF);
    chk("R3 clear all", pad_out, 32'h0);

    // Pin level change in the same cycle a burst of reads begins
    @(negedge clk); pad_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    pad_in = 32'hCAFE_0001;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = A_PIN;
    @(negedge clk);
    chk("R6 burst read 1 old level", bus_rdata, 32'h1234_5678);
    chk("R9 burst ack 1", {31'd0, bus_ack}, 32'h1);
    @(negedge clk);
    chk("R6 burst read 2 old level", bus_rdata, 32'h1234_5678);
    @(negedge clk);
    chk("R6 burst read 3 new level", bus_rdata, 32'hCAFE_0001);
    bus_req = 1'b0;
    @(negedge clk);
    chk("R9 ack drops", {31'd0, bus_ack}, 32'h0);
    chk("R9 rdata quiet", bus_rdata, 32'h0);

    // Random mixed traffic, judged cycle by cycle by the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      bus_req = ($urandom_range(0, 3) != 0);
      bus_we = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 7))
        0: bus_addr = A_OSET;
        1: bus_addr = A_OCLR;
        2: bus_addr = A_ESET;
        3: bus_addr = A_ECLR;
        4: bus_addr = A_PIN;
        5: bus_addr = 8'h04;
        6: bus_addr = 8'h50;
        default: bus_addr = 8'(A_PIN + 8'(i % 2));
      endcase
      bus_wdata = ($urandom_range(0, 5) == 0) ? 32'h0 : $urandom;
      if ($urandom_range(0, 2) == 0) pad_in = $urandom;
    end
    @(negedge clk);
    bus_req = 1'b0;
    repeat (3) @(negedge clk);
    run_cmp = 1'b0;
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule